// File: doc/BRIEF.md
# Cascaded Interval Timer Unit

This block holds three programmable interval timers that all advance on one shared tick enable. The first timer is a 16-bit down-counter that steps on every tick. The other two timers step only when a separate 12-bit base prescaler runs out, so their periods are multiples of the prescaler period. One is a 4-bit timer and the other is a 16-bit timer.

Software programs the block through byte-wide reload registers and one control register. The control register holds a start bit and an active-high interrupt mask bit for each timer, plus a start bit for the prescaler. When a timer runs out it sets a sticky flag in a status byte. Reading that byte through a strobe clears every flag.

A registered interrupt line combines the unmasked flags with pending bits from other sources, which arrive on a plain input vector. Those external bits are also shown in the low nibble of the status byte.

Top module: `cascade_timer_unit`

## Requirements
- R1: After reset `statusOut` is 0x00 and `irq` is low while `extPending` is zero.
- R2: With control bit 0 set, timer A (reload `{reg1, reg0}`) expires once every R ticks for a nonzero reload R and sets status bit 4. The write addresses are reg0 at 0, reg1 at 1, reg2 at 2, reg3 at 3, reg4 at 4, reg5 at 5 and control at 6.
- R3: A reload of zero on timer A gives a period of 65536 ticks.
- R4: The prescaler runs while control bit 3 is set and has the period P = `{reg3[3:0], reg2}`. Timer B (control bit 1, reload `reg3[7:4]`) steps once per prescaler expiry and sets status bit 5 after N·P ticks. A reload N of zero counts as 16.
- R5: Timer C (control bit 2, reload `{reg5, reg4}`) steps once per prescaler expiry and sets status bit 6 after M·P ticks.
- R6: A prescaler reload of zero gives P = 4096. The upper nibble of P comes from `reg3[3:0]`.
- R7: No counter advances while `tick` is low or while its start bit is clear, and no flag is set then.
- R8: A counter is loaded from its reload registers only when a control write changes its start bit from 0 to 1. A control write that leaves the start bit set does not restart the count.
- R9: `statusOut` is `{1'b0, C flag, B flag, A flag, extPending[3:0]}`. A cycle with `statusRd` high clears all three flags at the next edge.
- R10: `irq` is registered. It is high when any flag whose mask bit (control bits 4, 5 and 6 for A, B and C) is clear would be set after the edge, or when any `extPending` bit is high. It is low in the cycle after a status read if no expiry and no external bit is present.
- R11: An expiry in the same cycle as a status read or a register write still sets its flag, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for the timer unit |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| statusRd | input | 1 | Status read strobe that clears the flags |
| extPending | input | 4 | Pending bits from other interrupt sources |
| statusOut | output | 8 | Status byte |
| irq | output | 1 | Registered interrupt request |

## Verification
Periods are measured by counting ticks until a flag appears.

- **Timer A** is swept over a contiguous range of reload values and also given a zero reload. This tells a correct reload-on-one counter apart from off-by-one and zero-handling faults.
- **Timer B** is swept over every reload for several prescaler values. A product period separates true cascading from direct ticking, and a prescaler with a nonzero upper nibble exposes a wrong register split.
- **Restart, gating and collision patterns** tell edge-triggered loading apart from level loading. They also confirm that flags survive a clear or a write in the same cycle as an expiry.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int EXT_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_A_LO   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_A_HI   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PRE_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SPLIT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_C_LO   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_C_HI   = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd6;

  // control bit positions
  localparam int CB_RUN_A   = 0;
  localparam int CB_RUN_B   = 1;
  localparam int CB_RUN_C   = 2;
  localparam int CB_RUN_PRE = 3;
  localparam int CB_MASK_LO = 4;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic loadC;
    logic loadPre;
  } loadStrobes_t;

  typedef struct packed {
    logic runA;
    logic runB;
    logic runC;
    logic runPre;
  } runEnables_t;

  typedef struct packed {
    logic expC;
    logic expB;
    logic expA;
  } expiry_t;
endpackage

// File: rtl/ctu_downcounter.sv
module ctu_downcounter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] reloadVal,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] count;

  // A value of zero wraps to all ones, which gives a full 2^W period.
  assign expire = step && !load && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (load) begin
      count <= reloadVal;
    end else if (step) begin
      count <= (count == ONE) ? reloadVal : count - ONE;
    end
  end
endmodule

// File: rtl/ctu_datapath.sv
module ctu_datapath
  import ctu_pkg::*;
#(
  parameter int A_W   = 16,
  parameter int B_W   = 4,
  parameter int C_W   = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  loadStrobes_t     loads,
  input  runEnables_t      runs,
  input  logic [A_W-1:0]   reloadA,
  input  logic [B_W-1:0]   reloadB,
  input  logic [C_W-1:0]   reloadC,
  input  logic [PRE_W-1:0] reloadPre,
  output expiry_t          expiry
);
  logic preExpire;
  logic stepA;
  logic stepPre;
  logic stepB;
  logic stepC;

  assign stepA   = tick && runs.runA;
  assign stepPre = tick && runs.runPre;
  assign stepB   = preExpire && runs.runB;
  assign stepC   = preExpire && runs.runC;

  ctu_downcounter #(.W(A_W)) u_cntA (
    .clk(clk), .rstN(rstN), .load(loads.loadA), .step(stepA),
    .reloadVal(reloadA), .expire(expiry.expA)
  );

  ctu_downcounter #(.W(PRE_W)) u_cntPre (
    .clk(clk), .rstN(rstN), .load(loads.loadPre), .step(stepPre),
    .reloadVal(reloadPre), .expire(preExpire)
  );

  ctu_downcounter #(.W(B_W)) u_cntB (
    .clk(clk), .rstN(rstN), .load(loads.loadB), .step(stepB),
    .reloadVal(reloadB), .expire(expiry.expB)
  );

  ctu_downcounter #(.W(C_W)) u_cntC (
    .clk(clk), .rstN(rstN), .load(loads.loadC), .step(stepC),
    .reloadVal(reloadC), .expire(expiry.expC)
  );
endmodule

// File: rtl/ctu_control.sv
module ctu_control
  import ctu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statusRd,
  input  logic [EXT_W-1:0]  extPending,
  input  expiry_t           expiry,
  output loadStrobes_t      loads,
  output runEnables_t       runs,
  output logic [15:0]       reloadA,
  output logic [3:0]        reloadB,
  output logic [15:0]       reloadC,
  output logic [11:0]       reloadPre,
  output logic [7:0]        statusOut,
  output logic              irq
);
  logic [7:0] aLo, aHi, preLo, splitReg, cLo, cHi, ctrl;
  logic [2:0] flags;
  logic [2:0] flagsNext;
  logic [2:0] maskNext;
  logic       ctrlWr;
  logic [7:0] ctrlNext;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign ctrlNext = ctrlWr ? wrData : ctrl;

  // Loads fire only on a 0 -> 1 change of a start bit.
  assign loads.loadA   = ctrlWr && wrData[CB_RUN_A]   && !ctrl[CB_RUN_A];
  assign loads.loadB   = ctrlWr && wrData[CB_RUN_B]   && !ctrl[CB_RUN_B];
  assign loads.loadC   = ctrlWr && wrData[CB_RUN_C]   && !ctrl[CB_RUN_C];
  assign loads.loadPre = ctrlWr && wrData[CB_RUN_PRE] && !ctrl[CB_RUN_PRE];

  assign runs.runA   = ctrl[CB_RUN_A];
  assign runs.runB   = ctrl[CB_RUN_B];
  assign runs.runC   = ctrl[CB_RUN_C];
  assign runs.runPre = ctrl[CB_RUN_PRE];

  assign reloadA   = {aHi, aLo};
  assign reloadB   = splitReg[7:4];
  assign reloadC   = {cHi, cLo};
  assign reloadPre = {splitReg[3:0], preLo};

  assign flagsNext = (statusRd ? 3'b000 : flags) | {expiry.expC, expiry.expB, expiry.expA};
  assign maskNext  = ctrlNext[CB_MASK_LO +: 3];

  assign statusOut = {1'b0, flags, extPending};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aLo      <= '0;
      aHi      <= '0;
      preLo    <= '0;
      splitReg <= '0;
      cLo      <= '0;
      cHi      <= '0;
      ctrl     <= '0;
      flags    <= '0;
      irq      <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          ADDR_A_LO:   aLo      <= wrData;
          ADDR_A_HI:   aHi      <= wrData;
          ADDR_PRE_LO: preLo    <= wrData;
          ADDR_SPLIT:  splitReg <= wrData;
          ADDR_C_LO:   cLo      <= wrData;
          ADDR_C_HI:   cHi      <= wrData;
          ADDR_CTRL:   ctrl     <= wrData;
          default:     ;
        endcase
      end
      flags <= flagsNext;
      irq   <= (|(flagsNext & ~maskNext)) || (|extPending);
    end
  end
endmodule

// File: rtl/cascade_timer_unit.sv
module cascade_timer_unit
  import ctu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        statusRd,
  input  logic [3:0]  extPending,
  output logic [7:0]  statusOut,
  output logic        irq
);
  loadStrobes_t loads;
  runEnables_t  runs;
  expiry_t      expiry;
  logic [15:0]  reloadA;
  logic [3:0]   reloadB;
  logic [15:0]  reloadC;
  logic [11:0]  reloadPre;
  logic         expiryAny;

  assign expiryAny = |expiry;

  ctu_control u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusRd(statusRd), .extPending(extPending), .expiry(expiry),
    .loads(loads), .runs(runs), .reloadA(reloadA), .reloadB(reloadB),
    .reloadC(reloadC), .reloadPre(reloadPre), .statusOut(statusOut), .irq(irq)
  );

  ctu_datapath u_datapath (
    .clk(clk), .rstN(rstN), .tick(tick), .loads(loads), .runs(runs),
    .reloadA(reloadA), .reloadB(reloadB), .reloadC(reloadC),
    .reloadPre(reloadPre), .expiry(expiry)
  );
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       statusRd,
  input logic [3:0] extPending,
  input logic [7:0] statusOut,
  input logic       irq,
  input logic       expiryAny
);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !expiryAny) |=> (statusOut[6:4] == 3'b000));

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !expiryAny && (extPending == 4'h0)) |=> !irq);

  // R2
  a_flag_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[4]) |-> $past(tick));

  // R5
  c_flag_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[6]) |-> $past(tick));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !statusRd) |=> $stable(statusOut[6:4]));
endmodule

bind cascade_timer_unit ctu_checker u_ctu_checker (
  .clk(clk), .rstN(rstN), .tick(tick), .statusRd(statusRd),
  .extPending(extPending), .statusOut(statusOut), .irq(irq),
  .expiryAny(expiryAny)
);

// File: tb/test_cascade_timer_unit.sv
module test_cascade_timer_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       statusRd = 1'b0;
  logic [3:0] extPending = '0;
  logic [7:0] statusOut;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  cascade_timer_unit i_cascade_timer_unit (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .statusRd(statusRd), .extPending(extPending),
    .statusOut(statusOut), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdStatus(output logic [7:0] v);
    @(negedge clk);
    v = statusOut;
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  // Applies ticks until status bit idx appears or max is reached.
  task automatic countTicks(input int idx, input int max, output int n);
    n = 0;
    while (n < max) begin
      tick = 1'b1;
      @(negedge clk);
      n++;
      if (statusOut[idx]) break;
    end
    tick = 1'b0;
  endtask

  task automatic setup(input logic [7:0] ctrlVal, input logic [15:0] aVal,
                       input logic [7:0] preLo, input logic [7:0] split,
                       input logic [15:0] cVal);
    logic [7:0] dummy;
    wr(3'd6, 8'h00);
    wr(3'd0, aVal[7:0]);  wr(3'd1, aVal[15:8]);
    wr(3'd2, preLo);      wr(3'd3, split);
    wr(3'd4, cVal[7:0]);  wr(3'd5, cVal[15:8]);
    rdStatus(dummy);
    wr(3'd6, ctrlVal);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(statusOut == 8'h00, "R1 status", statusOut, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);

    // R2 sweep of timer A reloads
    for (int r = 1; r <= 40; r++) begin
      setup(8'h01, 16'(r), 8'h01, 8'h00, 16'h0001);
      countTicks(4, 100, n);
      check(n == r, "R2 A period", n, r);
    end
    setup(8'h01, 16'h0102, 8'h01, 8'h00, 16'h0001);
    countTicks(4, 400, n);
    check(n == 258, "R2 A two-byte reload", n, 258);

    // R3
    setup(8'h01, 16'h0000, 8'h01, 8'h00, 16'h0001);
    countTicks(4, 70000, n);
    check(n == 65536, "R3 A zero reload", n, 65536);

    // R4 sweep of timer B over prescaler values
    for (int p = 1; p <= 3; p++) begin
      for (int b = 1; b <= 15; b++) begin
        setup(8'h0A, 16'h0001, 8'(p), 8'(b << 4), 16'h0001);
        countTicks(5, 200, n);
        check(n == b * p, "R4 B period", n, b * p);
      end
    end
    setup(8'h0A, 16'h0001, 8'h01, 8'h00, 16'h0001);
    countTicks(5, 100, n);
    check(n == 16, "R4 B zero reload", n, 16);

    // R5 timer C, R6 split prescaler
    setup(8'h0C, 16'h0001, 8'h03, 8'h00, 16'd7);
    countTicks(6, 100, n);
    check(n == 21, "R5 C period", n, 21);
    setup(8'h0C, 16'h0001, 8'h05, 8'h01, 16'd2);
    countTicks(6, 1000, n);
    check(n == 522, "R6 prescaler upper nibble", n, 522);
    setup(8'h0C, 16'h0001, 8'h00, 8'h00, 16'd1);
    countTicks(6, 5000, n);
    check(n == 4096, "R6 prescaler zero reload", n, 4096);

    // R7 gating
    setup(8'h01, 16'h0001, 8'h01, 8'h00, 16'h0001);
    repeat (50) @(negedge clk);
    check(statusOut[6:4] == 3'b000, "R7 tick low", statusOut[6:4], 0);
    setup(8'h00, 16'h0001, 8'h01, 8'h10, 16'h0001);
    countTicks(4, 30, n);
    check(statusOut[6:4] == 3'b000, "R7 start clear", statusOut[6:4], 0);

    // R8 restart behaviour
    setup(8'h01, 16'd10, 8'h01, 8'h00, 16'h0001);
    countTicks(4, 6, n);
    wr(3'd6, 8'h01);
    countTicks(4, 50, n);
    check(n == 4, "R8 no reload on held start", n, 4);
    setup(8'h01, 16'd10, 8'h01, 8'h00, 16'h0001);
    countTicks(4, 6, n);
    wr(3'd6, 8'h00);
    wr(3'd6, 8'h01);
    countTicks(4, 50, n);
    check(n == 10, "R8 reload on start rise", n, 10);

    // R9 / R10 status and irq
    setup(8'h01, 16'd3, 8'h01, 8'h00, 16'h0001);
    countTicks(4, 10, n);
    check(statusOut == 8'h10, "R9 status layout", statusOut, 8'h10);
    check(irq == 1'b1, "R10 irq unmasked", irq, 1);
    rdStatus(st);
    check(st == 8'h10, "R9 read value", st, 8'h10);
    check(statusOut == 8'h00, "R9 cleared", statusOut, 0);
    check(irq == 1'b0, "R10 irq after read", irq, 0);
    setup(8'h11, 16'd3, 8'h01, 8'h00, 16'h0001);
    countTicks(4, 10, n);
    check(statusOut[4] == 1'b1, "R10 masked flag", statusOut[4], 1);
    check(irq == 1'b0, "R10 irq masked", irq, 0);
    rdStatus(st);
    extPending = 4'h2;
    @(negedge clk);
    check(irq == 1'b1, "R10 ext irq", irq, 1);
    check(statusOut == 8'h02, "R9 ext in status", statusOut, 2);
    extPending = 4'h0;
    @(negedge clk);
    check(irq == 1'b0, "R10 ext gone", irq, 0);

    // R11 collisions
    setup(8'h01, 16'd2, 8'h01, 8'h00, 16'h0001);
    tick = 1'b1;
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    tick = 1'b0;
    check(statusOut[4] == 1'b1, "R11 expiry beats clear", statusOut[4], 1);
    setup(8'h01, 16'd2, 8'h01, 8'h00, 16'h0001);
    tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'd5;
    @(negedge clk);
    wrEn = 1'b0;
    tick = 1'b0;
    check(statusOut[4] == 1'b1, "R11 expiry with write", statusOut[4], 1);
    rdStatus(st);
    wr(3'd6, 8'h00);
    wr(3'd6, 8'h01);
    countTicks(4, 20, n);
    check(n == 5, "R11 write kept", n, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule